// File: doc/BRIEF.md
# Field Element Load Unit

This unit moves one degree-three extension-field element from the general register file into a dedicated field-storage memory. A caller raises `start` together with a two-word call identifier and a timestamp. When the identifier selects this operation and the unit is idle, it reads the destination address from register 10. It then reads the three coefficients from registers 11, 12 and 13, using one read per cycle.

Each register read returns a low and a high 32-bit word. The unit joins them into a 64-bit coefficient with the high word in the upper half. It checks that each coefficient is a canonical member of the prime field with modulus 2^64 - 2^32 + 1. If all three pass, the unit performs three back-to-back writes. Coefficient i goes to storage bank 3 + i, and all three writes use the address read from register 10. If any coefficient fails the check, the unit skips the writes and reports an error when it finishes. Every read and write of one operation carries the timestamp captured at start. A one-cycle `done` closes each accepted operation.

Top module: `fld_load_unit`

## Requirements
- R1: A start is accepted only when the low identifier word is 0xFFFFFFEC and the high word is 0xFFFFFFFF. Any other identifier causes no register read, no write and no `done`.
- R2: After an accepted start, `rd_en` is high for four consecutive cycles, beginning the cycle after start is sampled. `rd_idx` takes the values 10, 11, 12 and 13 in that order.
- R3: Coefficient i is the value rd_hi * 2^32 + rd_lo returned for register 11 + i. Register 10 is read the same way and gives the 64-bit write address.
- R4: A coefficient of 0xFFFFFFFF00000000 or less is in range. A value of 0xFFFFFFFF00000001 or more is out of range.
- R5: When all coefficients are in range, `wr_en` is high for three consecutive cycles right after the last read. `wr_bank` is 3, 4 and 5 in order, `wr_data` is coefficients 0, 1 and 2 in order, and `wr_addr` is the register-10 address on every write.
- R6: If any coefficient is out of range, `wr_en` stays low for the whole operation, and `err` is high during `done`. The error does not carry over into the next operation.
- R7: `rd_stamp` and `wr_stamp` equal the `stamp` value sampled with the accepted start, on every read and every write of that operation.
- R8: `done` is high for exactly one cycle. That cycle follows the last write, or the last read when the operation failed. `err` is never high without `done`.
- R9: A start that arrives while an operation is in progress has no effect. The running operation keeps its reads, writes and timestamp.
- R10: While reset is applied, and until it is released, `done`, `err`, `rd_en` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request |
| call_lo | input | 32 | Call identifier, low word |
| call_hi | input | 32 | Call identifier, high word |
| stamp | input | 32 | Timestamp for the operation |
| rd_en | output | 1 | Register read strobe |
| rd_idx | output | 5 | Register index being read |
| rd_stamp | output | 32 | Timestamp sent with the read |
| rd_lo | input | 32 | Read data, low word (same cycle) |
| rd_hi | input | 32 | Read data, high word (same cycle) |
| wr_en | output | 1 | Field-storage write strobe |
| wr_bank | output | 3 | Destination bank (3 to 5) |
| wr_addr | output | 64 | Field-storage address |
| wr_data | output | 64 | Coefficient being written |
| wr_stamp | output | 32 | Timestamp sent with the write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Range failure, valid with done |

## Verification
The bench puts coefficients exactly at the largest canonical value and exactly at the modulus. A comparator that is off by one either writes the modulus or rejects the largest valid value. It sets the high and low words to distinct patterns, so a design that swaps the halves writes the wrong data. It sends a start during a running operation with a fresh timestamp, which exposes a unit that restarts, reads twice or picks up the new stamp. After a failed operation it runs a good one, which shows whether a stale error flag suppresses the writes.

// File: rtl/fld_load_pkg.sv
package fld_load_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_t;

  // Largest canonical element of the prime field p = 2^64 - 2^32 + 1
  localparam logic [63:0] FIELD_MAX = 64'hFFFF_FFFF_0000_0000;

endpackage

// File: rtl/fld_call_match.sv
module fld_call_match #(
  parameter int WORD_W   = 32,
  parameter int CALL_NUM = 20
) (
  input  logic              start,
  input  logic [WORD_W-1:0] call_lo,
  input  logic [WORD_W-1:0] call_hi,
  input  logic              busy,
  output logic              accept
);
  // Negative call number in two words of two's complement
  localparam logic [WORD_W-1:0] ID_LO = {WORD_W{1'b0}} - WORD_W'(CALL_NUM);
  localparam logic [WORD_W-1:0] ID_HI = {WORD_W{1'b1}};

  logic id_hit;

  always_comb begin
    id_hit = (call_lo == ID_LO) && (call_hi == ID_HI);
    accept = start && !busy && id_hit;
  end
endmodule

// File: rtl/fld_coeff_check.sv
module fld_coeff_check #(
  parameter int          WORD_W = 32,
  parameter logic [63:0] MAX_OK = fld_load_pkg::FIELD_MAX,
  localparam int         VAL_W  = 2 * WORD_W
) (
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  output logic [VAL_W-1:0]  value,
  output logic              in_range
);
  always_comb begin
    value    = {hi_word, lo_word};
    in_range = (value <= VAL_W'(MAX_OK));
  end
endmodule

// File: rtl/fld_coef_store.sv
module fld_coef_store #(
  parameter int  NUM   = 3,
  parameter int  DW    = 64,
  localparam int SEL_W = (NUM > 1) ? $clog2(NUM + 1) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM-1:0]   we,
  input  logic [DW-1:0]    din,
  input  logic [SEL_W-1:0] rsel,
  output logic [DW-1:0]    dout
);
  logic [DW-1:0] slot_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (we[g]) begin
        slot_q[g] <= din;
      end
    end
  end

  always_comb begin
    dout = '0;
    for (int k = 0; k < NUM; k++) begin
      if (rsel == SEL_W'(k)) dout = slot_q[k];
    end
  end
endmodule

// File: rtl/fld_load_seq.sv
module fld_load_seq
  import fld_load_pkg::*;
#(
  parameter int  NUM_COEF = 3,
  localparam int NUM_RD   = NUM_COEF + 1,
  localparam int CNT_W    = $clog2(NUM_RD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             bad_any,
  output seq_state_t       state,
  output logic [CNT_W-1:0] cnt
);
  seq_state_t       state_d;
  logic [CNT_W-1:0] cnt_d;
  logic             step_en;

  always_comb begin
    state_d = state;
    cnt_d   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_READ;
          cnt_d   = '0;
        end
      end
      ST_READ: begin
        if (cnt == CNT_W'(NUM_RD - 1)) begin
          state_d = bad_any ? ST_FIN : ST_WRITE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt + 1'b1;
        end
      end
      ST_WRITE: begin
        if (cnt == CNT_W'(NUM_COEF - 1)) begin
          state_d = ST_FIN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
    step_en = (state != ST_IDLE) || accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (step_en) begin
      state <= state_d;
      cnt   <= cnt_d;
    end
  end
endmodule

// File: rtl/fld_load_unit.sv
module fld_load_unit
  import fld_load_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int TS_W      = 32,
  parameter int IDX_W     = 5,
  parameter int BANK_W    = 3,
  parameter int NUM_COEF  = 3,
  parameter int ADDR_REG  = 10,
  parameter int BANK_BASE = 3,
  parameter int CALL_NUM  = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WORD_W-1:0]   call_lo,
  input  logic [WORD_W-1:0]   call_hi,
  input  logic [TS_W-1:0]     stamp,
  output logic                rd_en,
  output logic [IDX_W-1:0]    rd_idx,
  output logic [TS_W-1:0]     rd_stamp,
  input  logic [WORD_W-1:0]   rd_lo,
  input  logic [WORD_W-1:0]   rd_hi,
  output logic                wr_en,
  output logic [BANK_W-1:0]   wr_bank,
  output logic [2*WORD_W-1:0] wr_addr,
  output logic [2*WORD_W-1:0] wr_data,
  output logic [TS_W-1:0]     wr_stamp,
  output logic                done,
  output logic                err
);
  localparam int VAL_W = 2 * WORD_W;
  localparam int CNT_W = $clog2(NUM_COEF + 2);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             busy, accept;
  logic [VAL_W-1:0] rd_value;
  logic             rd_ok, coef_rd, bad_now;
  logic             err_q, err_d, err_en;
  logic [TS_W-1:0]  stamp_q;
  logic [VAL_W-1:0] addr_q;
  logic             addr_en;
  logic [NUM_COEF-1:0] coef_we;
  logic [VAL_W-1:0] store_out;

  assign busy = (state != ST_IDLE);

  fld_call_match #(.WORD_W(WORD_W), .CALL_NUM(CALL_NUM)) u_match (
    .start  (start),
    .call_lo(call_lo),
    .call_hi(call_hi),
    .busy   (busy),
    .accept (accept)
  );

  fld_coeff_check #(.WORD_W(WORD_W), .MAX_OK(FIELD_MAX)) u_check (
    .lo_word (rd_lo),
    .hi_word (rd_hi),
    .value   (rd_value),
    .in_range(rd_ok)
  );

  fld_load_seq #(.NUM_COEF(NUM_COEF)) u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .accept (accept),
    .bad_any(err_q | bad_now),
    .state  (state),
    .cnt    (cnt)
  );

  // Read-phase decode
  always_comb begin
    rd_en   = (state == ST_READ);
    coef_rd = rd_en && (cnt != '0);
    bad_now = coef_rd && !rd_ok;
    addr_en = rd_en && (cnt == '0);
    err_en  = accept || bad_now;
    err_d   = accept ? 1'b0 : 1'b1;
  end

  for (genvar g = 0; g < NUM_COEF; g++) begin : g_we
    assign coef_we[g] = rd_en && (cnt == CNT_W'(g + 1));
  end

  fld_coef_store #(.NUM(NUM_COEF), .DW(VAL_W)) u_store (
    .clk  (clk),
    .rst_n(rst_int_n),
    .we   (coef_we),
    .din  (rd_value),
    .rsel (cnt[$clog2(NUM_COEF + 1)-1:0]),
    .dout (store_out)
  );

  // Per-operation context registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stamp_q <= '0;
    end else if (accept) begin
      stamp_q <= stamp;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= rd_value;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  // Output decode
  always_comb begin
    rd_idx   = IDX_W'(ADDR_REG) + IDX_W'(cnt);
    rd_stamp = stamp_q;
    wr_en    = (state == ST_WRITE);
    wr_bank  = BANK_W'(BANK_BASE) + BANK_W'(cnt);
    wr_addr  = addr_q;
    wr_data  = store_out;
    wr_stamp = stamp_q;
    done     = (state == ST_FIN);
    err      = done && err_q;
  end
endmodule

// File: rtl/fld_load_unit_chk.sv
module fld_load_unit_chk #(
  parameter int IDX_W  = 5,
  parameter int BANK_W = 3,
  parameter int TS_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [TS_W-1:0]   rd_stamp,
  input logic              wr_en,
  input logic [BANK_W-1:0] wr_bank,
  input logic [TS_W-1:0]   wr_stamp,
  input logic              done,
  input logic              err
);
  // Read indices climb by one across a burst (R2)
  p_rd_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

  // Read burst starts at the address register (R2)
  p_rd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> (rd_idx == IDX_W'(10)));

  // Writes only target banks 3..5 and never overlap reads (R5)
  p_bank_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_bank >= BANK_W'(3) && wr_bank <= BANK_W'(5) && !rd_en));

  // Timestamp held across the whole operation (R7)
  p_stamp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && $past(rd_en || wr_en)) |->
      ($stable(rd_stamp) && $stable(wr_stamp)));

  // done is a single pulse, err only with done (R8)
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // done follows the last write directly (R8)
  p_done_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> done);
endmodule

bind fld_load_unit fld_load_unit_chk #(
  .IDX_W (IDX_W),
  .BANK_W(BANK_W),
  .TS_W  (TS_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .rd_idx  (rd_idx),
  .rd_stamp(rd_stamp),
  .wr_en   (wr_en),
  .wr_bank (wr_bank),
  .wr_stamp(wr_stamp),
  .done    (done),
  .err     (err)
);

// File: tb/fld_load_unit_test.sv
module fld_load_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] MAXV  = 64'hFFFF_FFFF_0000_0000;
  localparam logic [63:0] PRIME = 64'hFFFF_FFFF_0000_0001;
  localparam logic [31:0] ID_LO = 32'hFFFF_FFEC;
  localparam logic [31:0] ID_HI = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] call_lo = '0, call_hi = '0, stamp = '0;
  logic        rd_en, wr_en, done, err;
  logic [4:0]  rd_idx;
  logic [31:0] rd_stamp, wr_stamp, rd_lo, rd_hi;
  logic [2:0]  wr_bank;
  logic [63:0] wr_addr, wr_data;

  logic [63:0] regs [32];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_lo = regs[rd_idx][31:0];
  assign rd_hi = regs[rd_idx][63:32];

  fld_load_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .call_lo(call_lo), .call_hi(call_hi),
    .stamp(stamp), .rd_en(rd_en), .rd_idx(rd_idx), .rd_stamp(rd_stamp),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_stamp(wr_stamp),
    .done(done), .err(err)
  );

  // Activity log, sampled at the falling edge
  int          cyc = 0;
  int          rd_n, wr_n, done_n, err_n, bad_err;
  int          last_rd_cyc, last_wr_cyc, done_cyc;
  logic [4:0]  rd_idx_l [16];
  logic [31:0] rd_ts_l  [16];
  logic [2:0]  wr_bank_l[16];
  logic [63:0] wr_addr_l[16];
  logic [63:0] wr_data_l[16];
  logic [31:0] wr_ts_l  [16];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rd_en && rd_n < 16) begin
      rd_idx_l[rd_n] = rd_idx;
      rd_ts_l[rd_n]  = rd_stamp;
      rd_n           = rd_n + 1;
      last_rd_cyc    = cyc;
    end
    if (wr_en && wr_n < 16) begin
      wr_bank_l[wr_n] = wr_bank;
      wr_addr_l[wr_n] = wr_addr;
      wr_data_l[wr_n] = wr_data;
      wr_ts_l[wr_n]   = wr_stamp;
      wr_n            = wr_n + 1;
      last_wr_cyc     = cyc;
    end
    if (done) begin
      done_n   = done_n + 1;
      done_cyc = cyc;
      if (err) err_n = err_n + 1;
    end
    if (err && !done) bad_err = bad_err + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    rd_n = 0; wr_n = 0; done_n = 0; err_n = 0; bad_err = 0;
    last_rd_cyc = -1; last_wr_cyc = -1; done_cyc = -1;
  endtask

  task automatic issue(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] ts);
    @(negedge clk);
    start = 1'b1; call_lo = lo; call_hi = hi; stamp = ts;
    @(negedge clk);
    start = 1'b0; stamp = 32'h0BAD_0BAD;
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  task automatic set_regs(input logic [63:0] a, input logic [63:0] c0,
                          input logic [63:0] c1, input logic [63:0] c2);
    regs[10] = a; regs[11] = c0; regs[12] = c1; regs[13] = c2;
  endtask

  // Full-success checks for one operation
  task automatic expect_ok(input string tag, input logic [31:0] ts);
    chk(rd_n == 4, {"R2 read count ", tag}, 64'(rd_n), 64'd4);
    for (int i = 0; i < 4 && i < rd_n; i++) begin
      chk(rd_idx_l[i] == 5'(10 + i), {"R2 read index ", tag}, 64'(rd_idx_l[i]), 64'(10 + i));
      chk(rd_ts_l[i] == ts, {"R7 read stamp ", tag}, 64'(rd_ts_l[i]), 64'(ts));
    end
    chk(wr_n == 3, {"R5 write count ", tag}, 64'(wr_n), 64'd3);
    for (int i = 0; i < 3 && i < wr_n; i++) begin
      chk(wr_bank_l[i] == 3'(3 + i), {"R5 bank ", tag}, 64'(wr_bank_l[i]), 64'(3 + i));
      chk(wr_addr_l[i] == regs[10], {"R5 address ", tag}, wr_addr_l[i], regs[10]);
      chk(wr_data_l[i] == regs[11 + i], {"R3 coefficient ", tag}, wr_data_l[i], regs[11 + i]);
      chk(wr_ts_l[i] == ts, {"R7 write stamp ", tag}, 64'(wr_ts_l[i]), 64'(ts));
    end
    chk(last_wr_cyc == last_rd_cyc + 3, {"R5 writes follow reads ", tag},
        64'(last_wr_cyc), 64'(last_rd_cyc + 3));
    chk(done_n == 1, {"R8 done pulses ", tag}, 64'(done_n), 64'd1);
    chk(done_cyc == last_wr_cyc + 1, {"R8 done timing ", tag}, 64'(done_cyc), 64'(last_wr_cyc + 1));
    chk(err_n == 0 && bad_err == 0, {"R8 no error ", tag}, 64'(err_n + bad_err), 64'd0);
  endtask

  task automatic expect_fail(input string tag);
    chk(rd_n == 4, {"R6 read count ", tag}, 64'(rd_n), 64'd4);
    chk(wr_n == 0, {"R6 no write ", tag}, 64'(wr_n), 64'd0);
    chk(done_n == 1, {"R8 done pulses ", tag}, 64'(done_n), 64'd1);
    chk(err_n == 1, {"R6 error with done ", tag}, 64'(err_n), 64'd1);
    chk(done_cyc == last_rd_cyc + 1, {"R8 done after reads ", tag}, 64'(done_cyc), 64'(last_rd_cyc + 1));
    chk(bad_err == 0, {"R8 err only with done ", tag}, 64'(bad_err), 64'd0);
  endtask

  task automatic test_reset();
    chk(!done && !err && !rd_en && !wr_en, "R10 reset outputs",
        64'({done, err, rd_en, wr_en}), 64'd0);
  endtask

  task automatic test_basic();
    set_regs(64'h0000_0042_0000_1000, 64'h1234_5678_9ABC_DEF0,
             64'h0000_0001_FFFF_FFFF, 64'h7FFF_0000_0000_0003);
    clear_log(); issue(ID_LO, ID_HI, 32'hA5A5_0001); settle();
    expect_ok("basic", 32'hA5A5_0001);
  endtask

  task automatic test_boundary_ok();
    set_regs(64'hFFFF_FFFF_FFFF_FFF0, MAXV, 64'd0, MAXV);
    clear_log(); issue(ID_LO, ID_HI, 32'h0000_0777); settle();
    expect_ok("R4 max value", 32'h0000_0777);
  endtask

  task automatic test_prime_rejected();
    set_regs(64'h10, 64'd5, PRIME, 64'd6);
    clear_log(); issue(ID_LO, ID_HI, 32'h55); settle();
    expect_fail("R4 modulus");
    set_regs(64'h20, 64'd1, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    clear_log(); issue(ID_LO, ID_HI, 32'h56); settle();
    expect_fail("R6 last coeff");
  endtask

  task automatic test_err_clears();
    set_regs(64'h30, 64'd9, 64'd8, 64'd7);
    clear_log(); issue(ID_LO, ID_HI, 32'h99); settle();
    expect_ok("R6 recovery", 32'h99);
  endtask

  task automatic test_bad_id();
    clear_log(); issue(32'hFFFF_FFEB, ID_HI, 32'h1); settle();
    chk(rd_n == 0 && wr_n == 0 && done_n == 0, "R1 wrong low word",
        64'(rd_n + wr_n + done_n), 64'd0);
    clear_log(); issue(ID_LO, 32'h0, 32'h2); settle();
    chk(rd_n == 0 && wr_n == 0 && done_n == 0, "R1 wrong high word",
        64'(rd_n + wr_n + done_n), 64'd0);
  endtask

  task automatic test_busy_start();
    set_regs(64'h0000_0001_0000_0040, 64'd11, 64'd22, 64'd33);
    clear_log();
    issue(ID_LO, ID_HI, 32'hCAFE_0001);
    issue(ID_LO, ID_HI, 32'hDEAD_0002);
    settle();
    expect_ok("R9 busy start", 32'hCAFE_0001);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'(i) * 64'h0101_0101;
    clear_log();
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_basic();
    test_boundary_ok();
    test_prime_rejected();
    test_err_clears();
    test_bad_id();
    test_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule